// File: doc/BRIEF.md
# PMIC Register-Access Bus Bridge

This block sits between a processor register bus and an external power-management companion chip. It turns register-bus accesses into serial frames on a three-wire link: a serial clock, a frame enable, and one data line in each direction. The processor sees a small page of control registers at the bottom of the bridge's address space, plus a 4 KB window at offset 0x8000 that mirrors the companion chip's registers.

A store anywhere in the window is posted. It is placed in a write queue and sent out later as a write frame. A load from the companion chip is a two-step affair. Software writes the target address to a command register, which launches a read frame with no further start bit. Software then polls a result register. That register holds a busy flag, the returned 16-bit value and an echo of the address that was actually fetched. Queued writes always leave the bridge before a read frame, so a read returns the effect of every store issued ahead of it.

Each frame holds 29 bits, sent MSB first: a direction bit (1 = read), a 12-bit register address and 16 data bits. The serial clock is the system clock divided by an even parameter. Between frames the serial clock either stops low or, if software asks for it, runs freely.

Top module: `pmic_bridge`

## Requirements
- R1: A bus write to byte address 0x8000 + A, with A in 0..0xFFF, enqueues one write. It later leaves as one frame of direction bit 0, the 12-bit address A and the data wdata_i[15:0]. The frame is sent MSB first: sdo_o carries the direction bit first and data bit 0 last.
- R2: Writing wdata_i[11:0] to the read-command register (offset 0x28) starts a read of that address on its own. From the next bus read onward, bit 31 of the result register (offset 0x2C) reads 1.
- R3: When a read finishes, bit 31 of 0x2C returns to 0. Bits 15:0 then hold the 16 bits the companion chip drove during the data phase, and bits 30:16 hold the address that was read, zero-extended from 12 bits.
- R4: The queue status register (offset 0x30) shows queue-full on bit 11 and queue-empty on bit 10. All its other bits read 0, apart from bit 12 (R5).
- R5: The write queue holds FIFO_DEPTH entries (16 by default). A window write that arrives while the queue is full is discarded and never reaches the link. It also sets a sticky overflow flag, bit 12 of 0x30. Writing 1 to bit 12 of 0x30 clears that flag.
- R6: Writes queued before a read command is accepted are all sent before that read's frame. A read of an address written just before it therefore returns the new value.
- R7: sen_o is high for exactly 29 × CLK_DIV system cycles per frame, and sclk_o is low when sen_o rises. The bridge changes sdo_o while sclk_o is low. It samples sdi_i when sclk_o rises, for the 16 bit times that follow the address.
- R8: When bit 30 of the configuration register (offset 0x20) is 1, sclk_o toggles every CLK_DIV/2 cycles even with no frame in progress. When that bit is 0, sclk_o stays low whenever no frame is in progress.
- R9: A read command written while bit 31 of 0x2C is 1 is ignored. No extra frame is sent, and the result that follows belongs to the first command.
- R10: After reset, offsets 0x04 (address-width control; 0 selects the 12-bit mode) and 0x20 read 0, offset 0x2C reads 0, and offset 0x30 reads 0x400. sen_o and sclk_o are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write access, 0 = read access |
| addr_i | input | BUS_AW | Byte address within the bridge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Register read data, combinational from addr_i |
| sclk_o | output | 1 | Serial clock to the companion chip |
| sen_o | output | 1 | Frame enable, high for one whole frame |
| sdo_o | output | 1 | Serial data to the companion chip |
| sdi_i | input | 1 | Serial data from the companion chip |

## Verification
The hardest state to reach is a full write queue while a frame is still being shifted out. The overflow flag and the discard path only come into play there. A frame lasts over a hundred system cycles, so the stimulus issues twenty window writes on consecutive cycles and then reads the queue status before the first frame has finished. Reads of the addresses that were discarded then show that they never reached the companion chip. A second hard point is a read command arriving while another read is in flight. It is covered by issuing two commands back to back and counting the frames on the link.

// File: rtl/pmic_bridge_pkg.sv
package pmic_bridge_pkg;
  localparam int REG_AW    = 12;
  localparam int REG_DW    = 16;
  localparam int FRAME_W   = 1 + REG_AW + REG_DW;
  localparam int DATA_BIT0 = 1 + REG_AW;  // first bit time of the data phase

  localparam logic [11:0] OFS_CTRL   = 12'h004;
  localparam logic [11:0] OFS_CFG    = 12'h020;
  localparam logic [11:0] OFS_RD_CMD = 12'h028;
  localparam logic [11:0] OFS_RD_RES = 12'h02C;
  localparam logic [11:0] OFS_QSTAT  = 12'h030;

  localparam int CFG_CLK_ON_BIT = 30;
  localparam int QS_EMPTY_BIT   = 10;
  localparam int QS_FULL_BIT    = 11;
  localparam int QS_OVF_BIT     = 12;

  typedef struct packed {
    logic [REG_AW-1:0] addr;
    logic [REG_DW-1:0] data;
  } wr_entry_t;
endpackage

// File: rtl/pmic_wr_fifo.sv
module pmic_wr_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 28
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_q];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= nxt(wr_q);
      if (pop_ok)  rd_q <= nxt(rd_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= data_i;
  end

  // R5
  fifo_pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  // R5
  fifo_no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/pmic_serial_engine.sv
module pmic_serial_engine
  import pmic_bridge_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clk_on_i,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               busy_o,
  output logic               rd_done_o,
  output logic [REG_DW-1:0]  rd_data_o,
  output logic               sclk_o,
  output logic               sen_o,
  output logic               sdo_o,
  input  logic               sdi_i
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int HC_W  = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BC_W  = $clog2(FRAME_W + 1);
  localparam int LEN   = FRAME_W * CLK_DIV;
  localparam int LEN_W = $clog2(LEN + 1) + 1;

  logic               active_q, is_rd_q, sclk_q, done_q;
  logic [HC_W-1:0]    half_q;
  logic [BC_W-1:0]    bit_q;
  logic [FRAME_W-1:0] shreg_q;
  logic [REG_DW-1:0]  rx_q;
  logic               half_end;

  assign half_end  = (half_q == HC_W'(HALF - 1));
  assign busy_o    = active_q;
  assign rd_done_o = done_q;
  assign rd_data_o = rx_q;
  assign sclk_o    = sclk_q;
  assign sen_o     = active_q;
  assign sdo_o     = active_q & shreg_q[FRAME_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      is_rd_q  <= 1'b0;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
      half_q   <= '0;
      bit_q    <= '0;
      shreg_q  <= '0;
      rx_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (start_i) begin
          active_q <= 1'b1;
          is_rd_q  <= frame_i[FRAME_W-1];
          shreg_q  <= frame_i;
          sclk_q   <= 1'b0;
          half_q   <= '0;
          bit_q    <= '0;
          rx_q     <= '0;
        end else if (clk_on_i) begin
          if (half_end) begin
            half_q <= '0;
            sclk_q <= ~sclk_q;
          end else begin
            half_q <= half_q + 1'b1;
          end
        end else begin
          sclk_q <= 1'b0;
          half_q <= '0;
        end
      end else if (half_end) begin
        half_q <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          if (is_rd_q && bit_q >= BC_W'(DATA_BIT0)) rx_q <= {rx_q[REG_DW-2:0], sdi_i};
        end else begin
          sclk_q <= 1'b0;
          if (bit_q == BC_W'(FRAME_W - 1)) begin
            active_q <= 1'b0;
            done_q   <= is_rd_q;
          end else begin
            bit_q   <= bit_q + 1'b1;
            shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
          end
        end
      end else begin
        half_q <= half_q + 1'b1;
      end
    end
  end

  // frame length checker counter
  logic [LEN_W-1:0] len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       len_q <= '0;
    else if (active_q) len_q <= len_q + 1'b1;
    else               len_q <= '0;
  end

  // R7
  frame_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sen_o) |-> len_q == LEN_W'(LEN));
  // R7
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !active_q);
  // R7
  sen_rise_low_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sen_o) |-> !sclk_o);
endmodule

// File: rtl/pmic_bridge.sv
module pmic_bridge
  import pmic_bridge_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int FIFO_DEPTH = 16,
  parameter int BUS_AW     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              sclk_o,
  output logic              sen_o,
  output logic              sdo_o,
  input  logic              sdi_i
);
  localparam int PG_W = BUS_AW - 12;
  localparam logic [PG_W-1:0] PAGE_REGS = '0;
  localparam logic [PG_W-1:0] PAGE_WIN  = PG_W'(8);  // window base 0x8000
  localparam int ENT_W = $bits(wr_entry_t);

  logic page_regs, page_win, bus_wr;
  logic push, ovf_clr, cmd_wr;
  assign page_regs = (addr_i[BUS_AW-1:12] == PAGE_REGS);
  assign page_win  = (addr_i[BUS_AW-1:12] == PAGE_WIN);
  assign bus_wr    = req_i && we_i;
  assign push      = bus_wr && page_win;
  assign cmd_wr    = bus_wr && page_regs && (addr_i[11:0] == OFS_RD_CMD);
  assign ovf_clr   = bus_wr && page_regs && (addr_i[11:0] == OFS_QSTAT) && wdata_i[QS_OVF_BIT];

  // write queue
  wr_entry_t q_in, q_out;
  logic      q_full, q_empty, q_pop;
  assign q_in = '{addr: addr_i[11:0], data: wdata_i[REG_DW-1:0]};

  pmic_wr_fifo #(.DEPTH(FIFO_DEPTH), .W(ENT_W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .data_i  (q_in),
    .pop_i   (q_pop),
    .data_o  (q_out),
    .full_o  (q_full),
    .empty_o (q_empty)
  );

  // registers
  logic [31:0]       ctrl_q, cfg_q;
  logic              ovf_q, rd_busy_q, rd_launched_q;
  logic [REG_AW-1:0] rd_addr_q, rd_echo_q;
  logic [REG_DW-1:0] rd_val_q;

  // engine arbitration: queued writes first
  logic               eng_busy, eng_start, sel_wr, eng_rd_done;
  logic [FRAME_W-1:0] eng_frame;
  logic [REG_DW-1:0]  eng_rd_data;
  assign sel_wr    = !q_empty;
  assign eng_start = !eng_busy && (sel_wr || (rd_busy_q && !rd_launched_q));
  assign q_pop     = eng_start && sel_wr;
  assign eng_frame = sel_wr ? {1'b0, q_out} : {1'b1, rd_addr_q, {REG_DW{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q        <= '0;
      cfg_q         <= '0;
      ovf_q         <= 1'b0;
      rd_busy_q     <= 1'b0;
      rd_launched_q <= 1'b0;
      rd_addr_q     <= '0;
      rd_echo_q     <= '0;
      rd_val_q      <= '0;
    end else begin
      if (bus_wr && page_regs && addr_i[11:0] == OFS_CTRL) ctrl_q <= wdata_i;
      if (bus_wr && page_regs && addr_i[11:0] == OFS_CFG)  cfg_q  <= wdata_i;
      if (push && q_full) ovf_q <= 1'b1;
      else if (ovf_clr)   ovf_q <= 1'b0;
      if (cmd_wr && !rd_busy_q) begin
        rd_busy_q     <= 1'b1;
        rd_launched_q <= 1'b0;
        rd_addr_q     <= wdata_i[REG_AW-1:0];
      end else if (eng_rd_done) begin
        rd_busy_q     <= 1'b0;
        rd_launched_q <= 1'b0;
        rd_echo_q     <= rd_addr_q;
        rd_val_q      <= eng_rd_data;
      end else if (eng_start && !sel_wr) begin
        rd_launched_q <= 1'b1;
      end
    end
  end

  pmic_serial_engine #(.CLK_DIV(CLK_DIV)) u_engine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clk_on_i  (cfg_q[CFG_CLK_ON_BIT]),
    .start_i   (eng_start),
    .frame_i   (eng_frame),
    .busy_o    (eng_busy),
    .rd_done_o (eng_rd_done),
    .rd_data_o (eng_rd_data),
    .sclk_o    (sclk_o),
    .sen_o     (sen_o),
    .sdo_o     (sdo_o),
    .sdi_i     (sdi_i)
  );

  // register read mux
  always_comb begin
    rdata_o = '0;
    if (page_regs) begin
      case (addr_i[11:0])
        OFS_CTRL:   rdata_o = ctrl_q;
        OFS_CFG:    rdata_o = cfg_q;
        OFS_RD_CMD: rdata_o = 32'(rd_addr_q);
        OFS_RD_RES: rdata_o = {rd_busy_q, 15'(rd_echo_q), rd_val_q};
        OFS_QSTAT: begin
          rdata_o[QS_EMPTY_BIT] = q_empty;
          rdata_o[QS_FULL_BIT]  = q_full;
          rdata_o[QS_OVF_BIT]   = ovf_q;
        end
        default:    rdata_o = '0;
      endcase
    end
  end

  // R2
  busy_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_busy_q) |-> $past(cmd_wr));
  // R3
  busy_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_busy_q) |-> $past(eng_rd_done));
  // R8
  gated_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_q[CFG_CLK_ON_BIT] && $past(!cfg_q[CFG_CLK_ON_BIT]) && !sen_o) |-> !sclk_o);
  // R6
  rd_after_writes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sen_o) && sdo_o) |-> $past(q_empty));
endmodule

// File: tb/pmic_bridge_tb.sv
module pmic_bridge_tb;
  localparam int CLK_DIV = 4;
  localparam int FLEN    = 29;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sclk, sen, sdo, sdi;

  always #2 clk = ~clk;

  pmic_bridge #(.CLK_DIV(CLK_DIV), .FIFO_DEPTH(16), .BUS_AW(16)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .sclk_o(sclk), .sen_o(sen),
    .sdo_o(sdo), .sdi_i(sdi));

  int checks = 0, failures = 0, cyc = 0;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; failures++;
      $display("FAIL R7 watchdog actual=%0d expected<%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  // companion-chip model
  logic [15:0] slave_mem [4096];
  logic [15:0] exp_mem   [4096];
  logic [28:0] s_frame = '0, last_frame = '0;
  int          s_cnt = 0, frames = 0, sclk_rises = 0;
  logic        s_rw = 1'b0;
  logic [11:0] s_addr = '0;

  always @(posedge sclk) begin
    sclk_rises++;
    if (sen) begin
      s_frame = {s_frame[27:0], sdo};
      s_cnt++;
      if (s_cnt == 13) begin
        s_rw   = s_frame[12];
        s_addr = s_frame[11:0];
      end
      if (s_cnt == FLEN) begin
        last_frame = s_frame;
        frames++;
        if (!s_rw) slave_mem[s_addr] = s_frame[15:0];
      end
    end
  end
  always @(negedge sen) s_cnt = 0;

  always_comb begin
    sdi = 1'b0;
    if (s_rw && s_cnt >= 13 && s_cnt < FLEN) sdi = slave_mem[s_addr][28 - s_cnt];
  end

  // frame enable length monitor
  int sen_len = 0, last_len = 0;
  always @(posedge clk) begin
    if (sen) sen_len++;
    else if (sen_len != 0) begin
      last_len = sen_len;
      sen_len  = 0;
    end
  end

  task automatic chk(string req_s, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req_s, act, exp);
    end
  endtask

  task automatic bus_write(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  function automatic logic [31:0] exp_result(logic [11:0] a);
    return {4'b0, a, exp_mem[a]};
  endfunction

  task automatic wait_not_busy(output logic [31:0] res);
    res = 32'hFFFF_FFFF;
    for (int i = 0; i < 20000; i++) begin
      bus_read(16'h002C, res);
      if (!res[31]) break;
    end
  endtask

  task automatic do_read(logic [11:0] a, output logic [31:0] res);
    bus_write(16'h0028, {20'b0, a});
    wait_not_busy(res);
  endtask

  logic [31:0] r;
  int          f0, rises0;

  initial begin
    for (int i = 0; i < 4096; i++) begin
      slave_mem[i] = 16'(i) ^ 16'hA5C3;
      exp_mem[i]   = 16'(i) ^ 16'hA5C3;
    end
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    bus_read(16'h0004, r); chk("R10 ctrl", r, 32'h0);
    bus_read(16'h0020, r); chk("R10 cfg", r, 32'h0);
    bus_read(16'h002C, r); chk("R10 result", r, 32'h0);
    bus_read(16'h0030, r); chk("R10 qstat", r, 32'h400);
    chk("R10 sen", {31'b0, sen}, 32'h0);
    chk("R10 sclk", {31'b0, sclk}, 32'h0);

    // R1 single write frame
    bus_write(16'h8123, 32'hFFFF_BEEF);
    exp_mem[12'h123] = 16'hBEEF;
    repeat (FLEN * CLK_DIV + 8) @(negedge clk);
    chk("R1 frame", {3'b0, last_frame}, {3'b0, 1'b0, 12'h123, 16'hBEEF});
    chk("R7 sen length", last_len, FLEN * CLK_DIV);
    bus_read(16'h0030, r); chk("R4 empty after drain", r, 32'h400);

    // R2/R3 read
    bus_write(16'h0028, 32'h0000_0ABC);
    bus_read(16'h002C, r); chk("R2 busy set", {31'b0, r[31]}, 32'h1);
    wait_not_busy(r);
    chk("R3 result", r, exp_result(12'hABC));
    chk("R7 read frame dir", {31'b0, last_frame[28]}, 32'h1);
    chk("R7 read sen length", last_len, FLEN * CLK_DIV);

    // R6 write then immediate read of same address
    bus_write(16'h8456, 32'h0000_1357);
    exp_mem[12'h456] = 16'h1357;
    do_read(12'h456, r);
    chk("R6 read sees write", r, exp_result(12'h456));

    // R9 second command while busy is ignored
    f0 = frames;
    bus_write(16'h0028, 32'h0000_0011);
    bus_write(16'h0028, 32'h0000_0022);
    wait_not_busy(r);
    repeat (FLEN * CLK_DIV + 8) @(negedge clk);
    chk("R9 first command wins", r, exp_result(12'h011));
    chk("R9 one frame only", frames - f0, 1);

    // R5 overflow: 20 back-to-back window writes
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      req = 1'b1; we = 1'b1; addr = 16'h8100 + 16'(k); wdata = 32'h5000 + 32'(k);
      if (k <= 16) exp_mem[12'h100 + 12'(k)] = 16'h5000 + 16'(k);
    end
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    bus_read(16'h0030, r); chk("R5 full and overflow", r, 32'h1800);
    do_read(12'h110, r); chk("R5 last accepted", r, exp_result(12'h110));
    do_read(12'h111, r); chk("R5 dropped write", r, exp_result(12'h111));
    do_read(12'h113, r); chk("R5 dropped write last", r, exp_result(12'h113));
    bus_read(16'h0030, r); chk("R5 overflow sticky", r, 32'h1400);
    bus_write(16'h0030, 32'h0000_1000);
    bus_read(16'h0030, r); chk("R5 overflow cleared", r, 32'h400);

    // R8 clock modes
    bus_write(16'h0020, 32'h4000_0000);
    bus_read(16'h0020, r); chk("R8 cfg readback", r, 32'h4000_0000);
    rises0 = sclk_rises;
    repeat (40) @(negedge clk);
    chk("R8 free-running clock", {31'b0, (sclk_rises - rises0) == 10}, 32'h1);
    bus_write(16'h8077, 32'h0000_2468);
    exp_mem[12'h077] = 16'h2468;
    do_read(12'h077, r); chk("R8 access with clock on", r, exp_result(12'h077));
    bus_write(16'h0020, 32'h0);
    repeat (4) @(negedge clk);
    rises0 = sclk_rises;
    repeat (40) @(negedge clk);
    chk("R8 gated clock", sclk_rises - rises0, 0);
    chk("R8 gated level", {31'b0, sclk}, 32'h0);

    // random mix, R1/R3/R6
    begin
      int pend = 0;
      for (int n = 0; n < 60; n++) begin
        logic [11:0] a;
        logic [15:0] d;
        a = 12'h200 + 12'($urandom % 16);
        d = 16'($urandom);
        if (($urandom % 3) != 0 && pend < 8) begin
          bus_write({4'h8, a}, {16'($urandom), d});
          exp_mem[a] = d;
          pend++;
        end else begin
          do_read(a, r);
          chk("R6 random read", r, exp_result(a));
          pend = 0;
        end
      end
      do_read(12'h200, r);
      chk("R3 final random read", r, exp_result(12'h200));
    end

    summary();
    $finish;
  end
endmodule